// File: doc/BRIEF.md
# Strobed Parallel Port with Configurable Flag Pins

This block is an 8-bit parallel port that exchanges bytes with an outside device by strobes. It sits on a simple processor register bus and offers two locations: a data location and a control/status location. A processor write to the data location loads an output latch and raises an output-full flag. The outside device drains that byte and acknowledges with an output strobe, which clears the flag. In the other direction, the device presents a byte and pulses an input strobe. The byte is captured into an input buffer and an input-full flag is raised. A processor read of the data location returns the byte and lowers that flag.

Two side pins, A and B, are each programmed by a two-bit field. A pin can drive a constant, show one of the full flags, or become an input. As an input, A picks what the port drives: the output latch or the control/status byte. B, as an input, can lock out both strobes. Both strobe inputs pass through a two-flop synchroniser and then an edge detector. Both full flags therefore react on the third rising clock edge after a strobe changes.

Top module: `hs_port`

## Requirements
- R1: After reset the control/status byte reads 0x00, `pin_dout` is 0x00, and both flag pins are enabled (`*_oe`=1) and drive 0.
- R2: A full write to address 0xD8 puts the byte on `pin_dout` from the next cycle and sets status bit 1, the output-full flag.
- R3: Status bit 0 is the input-full flag. With control bit 2 = 1, a falling edge on `in_stb_n` captures `pin_din` into the input buffer and sets bit 0 on the third rising clock edge after the pin changes. With bit 2 = 0, every cycle in which the synchronised strobe is low captures `pin_din` again and keeps bit 0 set.
- R4: A read of 0xD8 returns the input buffer and clears bit 0. If a capture happens in the same cycle, the flag stays set.
- R5: With control bit 3 = 1, only a rising edge on `out_stb` clears the output-full flag. With bit 3 = 0, only a falling edge clears it. The clear takes effect on the third rising clock edge after the pin changes.
- R6: Control bits 5:4 set the A pin. 00 drives 0 and 01 drives 1. 10 drives the output-full flag. In these three modes `aflag_oe`=1.
- R7: With bits 5:4 = 11, `aflag_oe`=0. `pin_dout` then shows the output latch while `aflag_in` is 0 and the control/status byte while it is 1.
- R8: Control bits 7:6 set the B pin. 00 drives 0, 01 drives 1, 10 drives the input-full flag, and 11 gives `bflag_oe`=0.
- R9: With bits 7:6 = 11 and `bflag_in` high, neither strobe has any effect. With `bflag_in` low, both strobes act normally.
- R10: Status bits 1:0 cannot be written from the bus. A write to 0xE8 loads bits 7:2 only.
- R11: A single-bit write (`bus_bwr` with index `bus_bsel` and value `bus_bval`) changes only the addressed bit. At 0xD8 it also sets the output-full flag. At 0xE8 it has no effect on bits 1:0.
- R12: Accesses to any other address change no state, and reads from such an address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Full-byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_bwr | input | 1 | Single-bit write strobe |
| bus_bsel | input | 3 | Bit index for single-bit write |
| bus_bval | input | 1 | Bit value for single-bit write |
| bus_rd | input | 1 | Read strobe (has a side effect at 0xD8) |
| bus_rdata | output | 8 | Read data, combinational |
| pin_din | input | 8 | Port input data |
| pin_dout | output | 8 | Port output data |
| in_stb_n | input | 1 | Input data strobe, active low |
| out_stb | input | 1 | Output data strobe, polarity programmable |
| aflag_in | input | 1 | A pin input value |
| aflag_out | output | 1 | A pin output value |
| aflag_oe | output | 1 | A pin output enable |
| bflag_in | input | 1 | B pin input value |
| bflag_out | output | 1 | B pin output value |
| bflag_oe | output | 1 | B pin output enable |

## Verification
The input strobe is tried in edge mode and in level mode. In level mode a held strobe with changing pin data shows whether the buffer keeps capturing, and a read during the capture shows that setting the flag wins over clearing it. The output strobe is toggled in both directions under each polarity setting, which tells the active edge apart from the ignored one. The same strobe patterns are repeated with B as a port enable, high and then low, to separate a locked port from an open one. Each flag-pin mode is stepped through against the flag it should mirror. A behavioural model compares every pin and every read on every clock.

// File: rtl/hs_port.sv
module hs_port #(
  parameter logic [7:0] DATA_ADDR = 8'hD8,
  parameter logic [7:0] CTRL_ADDR = 8'hE8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_bwr,
  input  logic [2:0] bus_bsel,
  input  logic       bus_bval,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_din,
  output logic [7:0] pin_dout,
  input  logic       in_stb_n,
  input  logic       out_stb,
  input  logic       aflag_in,
  output logic       aflag_out,
  output logic       aflag_oe,
  input  logic       bflag_in,
  output logic       bflag_out,
  output logic       bflag_oe
);
  logic [7:0] olat, ibuf;
  logic [7:2] ctl;
  logic       ibf, obf;
  logic [2:0] isy, osy;

  wire [7:0] csr   = {ctl, obf, ibf};
  wire [1:0] amode = ctl[5:4];
  wire [1:0] bmode = ctl[7:6];
  wire       gated = (bmode == 2'b11) && bflag_in;

  wire in_ev  = !gated && (ctl[2] ? (isy[2] & ~isy[1]) : ~isy[1]);
  wire out_ev = !gated && (ctl[3] ? (~osy[2] & osy[1]) : (osy[2] & ~osy[1]));

  wire dsel  = bus_addr == DATA_ADDR;
  wire csel  = bus_addr == CTRL_ADDR;
  wire d_wr  = bus_wr  & dsel;
  wire d_bwr = bus_bwr & dsel;
  wire c_wr  = bus_wr  & csel;
  wire c_bwr = bus_bwr & csel;
  wire d_rd  = bus_rd  & dsel;

  wire [7:0] bmask = 8'd1 << bus_bsel;
  wire [7:0] bset  = bus_bval ? bmask : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olat <= '0;
      ibuf <= '0;
      ctl  <= '0;
      ibf  <= 1'b0;
      obf  <= 1'b0;
      isy  <= 3'b111;
      osy  <= 3'b111;
    end else begin
      isy <= {isy[1:0], in_stb_n};
      osy <= {osy[1:0], out_stb};

      if (in_ev) begin
        ibuf <= pin_din;
        ibf  <= 1'b1;
      end else if (d_rd) begin
        ibf  <= 1'b0;
      end

      if (d_wr) begin
        olat <= bus_wdata;
        obf  <= 1'b1;
      end else if (d_bwr) begin
        olat <= (olat & ~bmask) | bset;
        obf  <= 1'b1;
      end else if (out_ev) begin
        obf  <= 1'b0;
      end

      if (c_wr)
        ctl <= bus_wdata[7:2];
      else if (c_bwr)
        ctl <= (ctl & ~bmask[7:2]) | bset[7:2];
    end
  end

  assign bus_rdata = d_rd ? ibuf : (bus_rd && csel) ? csr : 8'h00;
  assign pin_dout  = (amode == 2'b11 && aflag_in) ? csr : olat;

  assign aflag_oe  = amode != 2'b11;
  assign aflag_out = (amode == 2'b10) ? obf : (amode == 2'b01);
  assign bflag_oe  = bmode != 2'b11;
  assign bflag_out = (bmode == 2'b10) ? ibf : (bmode == 2'b01);
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter logic [7:0] DATA_ADDR = 8'hD8,
  parameter logic [7:0] CTRL_ADDR = 8'hE8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_bwr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [7:0] pin_dout,
  input logic       aflag_in,
  input logic       aflag_out,
  input logic       bflag_in,
  input logic       bflag_oe,
  input logic [7:2] ctl,
  input logic       ibf,
  input logic       obf,
  input logic       in_ev,
  input logic       out_ev
);
  AST_DATA_WR_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR) |=> obf); // R2

  AST_READ_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_ADDR && !in_ev) |=> !ibf); // R4

  AST_FLAGS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && !bus_bwr && !out_ev) |=> obf == $past(obf)); // R10

  AST_STROBES_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7:6] == 2'b11 && bflag_in && !bus_rd) |=> ibf == $past(ibf)); // R9

  AST_SELECT_CSR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[5:4] == 2'b11 && aflag_in) |-> pin_dout == {ctl, obf, ibf}); // R7

  AST_APIN_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[5:4] == 2'b10) |-> aflag_out == obf); // R6

  AST_BPIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7:6] == 2'b11) |-> !bflag_oe); // R8

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != DATA_ADDR && bus_addr != CTRL_ADDR) |-> bus_rdata == 8'h00); // R12
endmodule

bind hs_port hs_port_chk #(.DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bwr(bus_bwr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_dout(pin_dout), .aflag_in(aflag_in),
  .aflag_out(aflag_out), .bflag_in(bflag_in), .bflag_oe(bflag_oe), .ctl(ctl),
  .ibf(ibf), .obf(obf), .in_ev(in_ev), .out_ev(out_ev)
);

// File: tb/sim_hs_port.sv
module sim_hs_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, pin_din = 8'h00;
  logic bus_wr = 0, bus_bwr = 0, bus_bval = 0, bus_rd = 0;
  logic [2:0] bus_bsel = 3'd0;
  logic in_stb_n = 1, out_stb = 1, aflag_in = 0, bflag_in = 0;
  logic [7:0] bus_rdata, pin_dout;
  logic aflag_out, aflag_oe, bflag_out, bflag_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hs_port u0 (.*);

  // behavioural reference
  logic [7:0] m_olat, m_ibuf, m_ctl;
  bit m_ibf, m_obf;
  bit is1, is2, is3, os1, os2, os3;

  function automatic logic [7:0] m_csr();
    return {m_ctl[7:2], m_obf, m_ibf};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_olat = 0; m_ibuf = 0; m_ctl = 0; m_ibf = 0; m_obf = 0;
      {is1, is2, is3, os1, os2, os3} = 6'b111111;
    end else begin
      bit lock, ein, eout;
      lock = (m_ctl[7:6] == 2'b11) && bflag_in;
      ein  = !lock && (m_ctl[2] ? (is3 && !is2) : !is2);
      eout = !lock && (m_ctl[3] ? (!os3 && os2) : (os3 && !os2));
      if (ein) begin m_ibuf = pin_din; m_ibf = 1; end
      else if (bus_rd && bus_addr == 8'hD8) m_ibf = 0;
      if (bus_wr && bus_addr == 8'hD8) begin m_olat = bus_wdata; m_obf = 1; end
      else if (bus_bwr && bus_addr == 8'hD8) begin m_olat[bus_bsel] = bus_bval; m_obf = 1; end
      else if (eout) m_obf = 0;
      if (bus_wr && bus_addr == 8'hE8) m_ctl = {bus_wdata[7:2], 2'b00};
      else if (bus_bwr && bus_addr == 8'hE8 && bus_bsel >= 3'd2) m_ctl[bus_bsel] = bus_bval;
      is3 = is2; is2 = is1; is1 = in_stb_n;
      os3 = os2; os2 = os1; os1 = out_stb;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    #1;
    if (rst_n) begin
      logic [7:0] er;
      logic       ao, bo;
      er = !bus_rd ? 8'h00 : (bus_addr == 8'hD8) ? m_ibuf : (bus_addr == 8'hE8) ? m_csr() : 8'h00;
      ao = (m_ctl[5:4] == 2'b10) ? m_obf : (m_ctl[5:4] == 2'b01);
      bo = (m_ctl[7:6] == 2'b10) ? m_ibf : (m_ctl[7:6] == 2'b01);
      chk("MODEL", {bus_rdata, pin_dout, aflag_out, aflag_oe, bflag_out, bflag_oe},
          {er, (m_ctl[5:4] == 2'b11 && aflag_in) ? m_csr() : m_olat,
           ao, m_ctl[5:4] != 2'b11, bo, m_ctl[7:6] != 2'b11});
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
  endtask

  task automatic bwr(logic [7:0] a, logic [2:0] b, logic v);
    bus_addr = a; bus_bsel = b; bus_bval = v; bus_bwr = 1; step(); bus_bwr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata; #0 step(); bus_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 pins", {pin_dout, aflag_out, aflag_oe, bflag_out, bflag_oe}, {8'h00, 4'b0101});
    rd(8'hE8, r); chk("R1 csr", r, 8'h00);

    wr(8'hD8, 8'hA5);
    chk("R2 dout", pin_dout, 8'hA5);
    rd(8'hE8, r); chk("R2 obf", r[1], 1);

    wr(8'hE8, 8'h04);
    out_stb = 0; idle(3);
    rd(8'hE8, r); chk("R5 falling clears", r[1], 0);
    out_stb = 1; idle(3);
    wr(8'hE8, 8'h0C); wr(8'hD8, 8'h3C);
    out_stb = 0; idle(4);
    rd(8'hE8, r); chk("R5 falling ignored", r[1], 1);
    out_stb = 1; idle(3);
    rd(8'hE8, r); chk("R5 rising clears", r[1], 0);

    pin_din = 8'h5A; in_stb_n = 0; idle(2);
    rd(8'hE8, r); chk("R3 latency", r[0], 0);
    rd(8'hE8, r); chk("R3 edge sets", r[0], 1);
    in_stb_n = 1;
    rd(8'hD8, r); chk("R4 data", r, 8'h5A);
    rd(8'hE8, r); chk("R4 cleared", r[0], 0);
    idle(4);
    rd(8'hE8, r); chk("R3 single edge", r[0], 0);

    wr(8'hE8, 8'h08);
    pin_din = 8'h11; in_stb_n = 0; idle(3);
    pin_din = 8'h22; idle(1);
    rd(8'hD8, r); chk("R3 level recapture", r, 8'h22);
    rd(8'hE8, r); chk("R4 set wins", r[0], 1);
    in_stb_n = 1; idle(3);
    rd(8'hD8, r);
    rd(8'hE8, r); chk("R4 cleared after release", r[0], 0);

    wr(8'hE8, 8'h03);
    rd(8'hE8, r); chk("R10 flags not written", r, 8'h00);
    wr(8'hD8, 8'h77); wr(8'hE8, 8'h00);
    rd(8'hE8, r); chk("R10 obf kept", r, 8'h02);

    wr(8'hE8, 8'h10); chk("R6 drive 1", {aflag_out, aflag_oe}, 2'b11);
    wr(8'hE8, 8'h20); chk("R6 obf shown", {aflag_out, aflag_oe}, 2'b11);
    out_stb = 0; idle(3);
    chk("R6 obf cleared", aflag_out, 0);
    out_stb = 1; idle(3);

    wr(8'hE8, 8'h30); chk("R7 oe off", aflag_oe, 0);
    chk("R7 latch shown", pin_dout, 8'h77);
    aflag_in = 1; step();
    chk("R7 csr shown", pin_dout, 8'h30);
    aflag_in = 0;

    wr(8'hE8, 8'h40); chk("R8 drive 1", {bflag_out, bflag_oe}, 2'b11);
    wr(8'hE8, 8'h80); chk("R8 ibf low", bflag_out, 0);
    pin_din = 8'h3E; in_stb_n = 0; idle(3);
    chk("R8 ibf shown", bflag_out, 1);
    in_stb_n = 1; idle(3);
    rd(8'hD8, r);

    wr(8'hE8, 8'hC4); chk("R8 oe off", bflag_oe, 0);
    bflag_in = 1; in_stb_n = 0; idle(4);
    rd(8'hE8, r); chk("R9 input locked", r[0], 0);
    in_stb_n = 1; idle(3);
    wr(8'hD8, 8'h99);
    out_stb = 0; idle(4);
    rd(8'hE8, r); chk("R9 output locked", r[1], 1);
    out_stb = 1; idle(3);
    bflag_in = 0; in_stb_n = 0; idle(4);
    rd(8'hE8, r); chk("R9 enabled", r[0], 1);
    in_stb_n = 1; idle(3);
    rd(8'hD8, r); chk("R9 data", r, 8'h3E);

    wr(8'hE8, 8'h00); wr(8'hD8, 8'h00);
    out_stb = 0; idle(3); out_stb = 1; idle(3);
    bwr(8'hD8, 3'd3, 1); chk("R11 data bit", pin_dout, 8'h08);
    bwr(8'hE8, 3'd4, 1); chk("R11 ctl bit", aflag_out, 1);
    bwr(8'hE8, 3'd1, 0);
    rd(8'hE8, r); chk("R11 flag bit kept", r, 8'h12);

    wr(8'h55, 8'hFF); chk("R12 no state", pin_dout, 8'h08);
    rd(8'hE8, r); chk("R12 csr kept", r, 8'h12);
    rd(8'h55, r); chk("R12 read zero", r, 8'h00);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule